// File: doc/BRIEF.md
# Serial Interrupt Host Sequencer

This block is the host end of a shared serial interrupt wire. It opens each interrupt cycle with a start pulse, listens to sixteen three-clock slots in which peripherals pull the wire low to signal an interrupt, and closes the cycle with a stop pulse. The length of the stop pulse tells every peripheral which mode the next cycle runs in. In continuous mode the host opens each cycle on its own. In quiet mode it waits for a peripheral to ask for a cycle with a one-clock low.

The captured slots are collected into a 16-bit vector, one bit per interrupt line. The vector is published once per cycle together with a one-clock valid strobe. Slot 3 can be steered either into the vector or onto a separate management interrupt output. The pad is outside the block: `line_oe`/`line_out` drive it and `line_in` returns the level on the wire.

Top module: `sirq_host`

## Requirements
- R1: During and straight after reset the wire is released (`line_oe`=0), `irq_status`=0, `mgmt_irq`=0, `status_valid`=0 and `mode_quiet`=0, which means continuous mode.
- R2: In continuous mode with `enable`=1, a start frame drives the wire low for 4 clocks, then drives it high for 1 clock, then releases it. After reset the first start frame begins in the clock after `enable` is first seen high.
- R3: Clock 0 is the clock in which the host drives the start frame high. Slot N (1..16) is sampled in clock 3N−1. A low sample sets bit N−1 of `irq_status` (bit k is interrupt k). A high sample leaves that bit at 0.
- R4: Slot 1 carries nothing, and bit 0 of `irq_status` is always 0.
- R5: When `slot3_to_mgmt`=1, slot 3 is reported on `mgmt_irq` and bit 2 reads 0. When it is 0, slot 3 sets bit 2 and `mgmt_irq` reads 0. Slot 14 lands in bit 13.
- R6: The stop pulse starts in clock 50 after the start rise. It is low for 2 clocks if `next_quiet`=1 or for 3 clocks if it is 0, followed by one driven-high clock and then release. `mode_quiet` shows the chosen mode from the first stop clock on.
- R7: `irq_status` and `mgmt_irq` change only in the first stop clock, when `status_valid` is high for exactly one clock. At all other times they hold.
- R8: In continuous mode the next start pulse begins in the second clock after the stop's driven-high clock, and no sooner.
- R9: In quiet mode the host never starts a cycle on its own. A one-clock low from a peripheral, from the second clock after the stop's high clock on, makes the host drive 3 more low clocks, 1 high clock, and then run the same slot timing.
- R10: In quiet mode a peripheral low in the first clock after the stop's high clock is ignored.
- R11: With `enable`=0 no new cycle is started, in either mode. A cycle already under way completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Permits new cycles to start |
| next_quiet | input | 1 | Mode encoded into the coming stop pulse (1 = quiet) |
| slot3_to_mgmt | input | 1 | Steers slot 3 to `mgmt_irq` instead of bit 2 |
| line_in | input | 1 | Level seen on the wire |
| line_oe | output | 1 | Host drives the wire when high |
| line_out | output | 1 | Level driven when `line_oe` is high |
| irq_status | output | 16 | Interrupt vector from the last cycle |
| mgmt_irq | output | 1 | Slot 3 when it is steered to management |
| status_valid | output | 1 | One-clock strobe when the vector is updated |
| mode_quiet | output | 1 | Mode of the cycle now in force (1 = quiet) |

## Verification
A reference model in the bench predicts the host drive, vector, strobe and mode in every clock and compares them with the design. The slot patterns are chosen to expose off-by-one sample timing:
- slots 1, 2, 5 and 16, which also shows that slot 1 is dropped;
- slots 3, 7 and 14 with management steering;
- all sixteen slots low.

Switching between a 2-clock and a 3-clock stop shows that the mode is encoded in the stop length. In quiet mode, a request one clock too early must be ignored while a request on time is answered, which separates the gap rule from the request response. A disabled stretch in continuous mode followed by re-enabling shows that start gating does not disturb the cycle in progress.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Sequencer phases of one interrupt cycle
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_FRAME,
    ST_STOP,
    ST_RISE
  } sirq_state_e;

  // Clocks per slot: sample, recovery, turnaround
  localparam int FRAME_CLKS = 3;

endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int SLOT_W     = 5,
  parameter int START_LOW  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              next_quiet,
  input  logic              line_in,
  output logic              line_oe,
  output logic              line_out,
  output logic              sample_stb,
  output logic [SLOT_W-1:0] sample_slot,
  output logic              frame_begin,
  output logic              frame_done,
  output logic              mode_quiet
);

  localparam int CNT_MAX = (START_LOW > STOP_CONT) ? START_LOW : STOP_CONT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PH_SMP  = FRAME_CLKS - 1;
  localparam int PH_END  = FRAME_CLKS - 2;

  sirq_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        ph_q, ph_d;
  logic [SLOT_W-1:0] sl_q, sl_d;
  logic [1:0]        gap_q, gap_d;
  logic              mode_q, mode_d;
  logic [CNT_W-1:0]  stop_last;
  logic              start_last;
  logic              frame_last;

  assign stop_last  = mode_q ? CNT_W'(STOP_QUIET - 1) : CNT_W'(STOP_CONT - 1);
  assign start_last = (st_q == ST_START) && (cnt_q == CNT_W'(START_LOW - 1));
  assign frame_last = (st_q == ST_FRAME) && (sl_q == SLOT_W'(SLOTS)) && (ph_q == 2'(PH_END));

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    sl_d   = sl_q;
    gap_d  = gap_q;
    mode_d = mode_q;
    unique case (st_q)
      ST_IDLE: begin
        if (gap_q != 2'd2) gap_d = gap_q + 2'd1;
        if (enable && !mode_q && (gap_q != 2'd0)) begin
          st_d  = ST_START;
          cnt_d = '0;
        end else if (enable && mode_q && (gap_q == 2'd2) && !line_in) begin
          // peripheral already supplied the first low clock
          st_d  = ST_START;
          cnt_d = CNT_W'(1);
        end
      end
      ST_START: begin
        if (start_last) begin
          st_d = ST_FRAME;
          ph_d = '0;
          sl_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_FRAME: begin
        if (frame_last) begin
          st_d   = ST_STOP;
          cnt_d  = '0;
          mode_d = next_quiet;
        end else if (ph_q == 2'(PH_SMP)) begin
          ph_d = '0;
          sl_d = sl_q + SLOT_W'(1);
        end else begin
          ph_d = ph_q + 2'd1;
        end
      end
      ST_STOP: begin
        if (cnt_q == stop_last) st_d = ST_RISE;
        else                    cnt_d = cnt_q + CNT_W'(1);
      end
      ST_RISE: begin
        st_d  = ST_IDLE;
        gap_d = 2'd1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ph_q   <= '0;
      sl_q   <= '0;
      gap_q  <= 2'd2;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      sl_q   <= sl_d;
      gap_q  <= gap_d;
      mode_q <= mode_d;
    end
  end

  // Wire drive and strobes
  logic frame_high;
  assign frame_high  = (st_q == ST_FRAME) && (ph_q == 2'd0) && (sl_q == '0);
  assign line_oe     = (st_q == ST_START) || (st_q == ST_STOP) || (st_q == ST_RISE) || frame_high;
  assign line_out    = (st_q == ST_RISE) || frame_high;
  assign sample_stb  = (st_q == ST_FRAME) && (ph_q == 2'(PH_SMP));
  assign sample_slot = sl_q + SLOT_W'(1);
  assign frame_begin = start_last;
  assign frame_done  = frame_last;
  assign mode_quiet  = mode_q;

  // R2: a driven-high clock is always followed by a non-high clock
  p_drive_high_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && line_out) |=> !(line_oe && line_out));

  // R8: the stop's high clock is always followed by an idle clock
  p_rise_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RISE) |=> (st_q == ST_IDLE));

  // R6: a third stop clock only in continuous mode
  p_stop_three_cont_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_STOP) && ($past(st_q) == ST_STOP) && ($past(st_q, 2) == ST_STOP)) |-> !mode_q);

  // R6: every stop pulse is at least two clocks long
  p_stop_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RISE) |-> (($past(st_q) == ST_STOP) && ($past(st_q, 2) == ST_STOP)));

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture #(
  parameter int SLOTS     = 16,
  parameter int SLOT_W    = 5,
  parameter int MGMT_SLOT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              route_mgmt,
  input  logic              sample_stb,
  input  logic [SLOT_W-1:0] sample_slot,
  input  logic              frame_begin,
  input  logic              frame_done,
  output logic [SLOTS-1:0]  irq_status,
  output logic              mgmt_irq,
  output logic              status_valid
);

  logic [SLOTS-1:0] sh_q, sh_d;
  logic             mg_q, mg_d;
  logic [SLOTS-1:0] stat_q, stat_d;
  logic             mgo_q, mgo_d;
  logic             vld_q;

  // Per-slot shadow bits
  for (genvar i = 0; i < SLOTS; i++) begin : g_bit
    localparam int SLOT_NUM = i + 1;
    if (i == 0) begin : g_unused
      assign sh_d[i] = 1'b0;
    end else if (SLOT_NUM == MGMT_SLOT) begin : g_shared
      logic hit;
      assign hit     = sample_stb && (sample_slot == SLOT_W'(SLOT_NUM)) && !line_in && !route_mgmt;
      assign sh_d[i] = frame_begin ? 1'b0 : (sh_q[i] | hit);
    end else begin : g_plain
      logic hit;
      assign hit     = sample_stb && (sample_slot == SLOT_W'(SLOT_NUM)) && !line_in;
      assign sh_d[i] = frame_begin ? 1'b0 : (sh_q[i] | hit);
    end
  end

  always_comb begin
    mg_d = frame_begin ? 1'b0 :
           (mg_q | (sample_stb && (sample_slot == SLOT_W'(MGMT_SLOT)) && !line_in && route_mgmt));
    stat_d = frame_done ? sh_q : stat_q;
    mgo_d  = frame_done ? mg_q : mgo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      mg_q   <= 1'b0;
      stat_q <= '0;
      mgo_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      mg_q   <= mg_d;
      stat_q <= stat_d;
      mgo_q  <= mgo_d;
      vld_q  <= frame_done;
    end
  end

  assign irq_status   = stat_q;
  assign mgmt_irq     = mgo_q;
  assign status_valid = vld_q;

  // R7: the strobe lasts exactly one clock
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |=> !status_valid);

  // R7: the vector moves only with the strobe
  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !status_valid |-> ($stable(irq_status) && $stable(mgmt_irq)));

  // R5: slot 3 never appears in both places
  p_route_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> !(irq_status[MGMT_SLOT-1] && mgmt_irq));

endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int SLOTS      = 16,
  parameter int START_LOW  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int MGMT_SLOT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             next_quiet,
  input  logic             slot3_to_mgmt,
  input  logic             line_in,
  output logic             line_oe,
  output logic             line_out,
  output logic [SLOTS-1:0] irq_status,
  output logic             mgmt_irq,
  output logic             status_valid,
  output logic             mode_quiet
);

  localparam int SLOT_W = $clog2(SLOTS + 1);

  logic              sample_stb;
  logic [SLOT_W-1:0] sample_slot;
  logic              frame_begin;
  logic              frame_done;

  sirq_seq #(
    .SLOTS      (SLOTS),
    .SLOT_W     (SLOT_W),
    .START_LOW  (START_LOW),
    .STOP_QUIET (STOP_QUIET),
    .STOP_CONT  (STOP_CONT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .next_quiet  (next_quiet),
    .line_in     (line_in),
    .line_oe     (line_oe),
    .line_out    (line_out),
    .sample_stb  (sample_stb),
    .sample_slot (sample_slot),
    .frame_begin (frame_begin),
    .frame_done  (frame_done),
    .mode_quiet  (mode_quiet)
  );

  sirq_capture #(
    .SLOTS     (SLOTS),
    .SLOT_W    (SLOT_W),
    .MGMT_SLOT (MGMT_SLOT)
  ) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_in      (line_in),
    .route_mgmt   (slot3_to_mgmt),
    .sample_stb   (sample_stb),
    .sample_slot  (sample_slot),
    .frame_begin  (frame_begin),
    .frame_done   (frame_done),
    .irq_status   (irq_status),
    .mgmt_irq     (mgmt_irq),
    .status_valid (status_valid)
  );

endmodule

// File: tb/tb_sirq_host.sv
module tb_sirq_host;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic next_quiet = 1'b0;
  logic slot3_to_mgmt = 1'b0;
  logic periph_low = 1'b0;
  logic line_in;
  logic line_oe, line_out;
  logic [15:0] irq_status;
  logic mgmt_irq, status_valid, mode_quiet;

  always #4 clk = ~clk;   // 125 MHz

  // wired line with pull-up
  assign line_in = periph_low ? 1'b0 : (line_oe ? line_out : 1'b1);

  sirq_host dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .next_quiet(next_quiet),
    .slot3_to_mgmt(slot3_to_mgmt), .line_in(line_in), .line_oe(line_oe),
    .line_out(line_out), .irq_status(irq_status), .mgmt_irq(mgmt_irq),
    .status_valid(status_valid), .mode_quiet(mode_quiet)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // peripheral configuration (set by the stimulus)
  logic [16:1] pend = '0;
  bit want_req = 1'b0;
  int req_s = 0;

  // peripheral line-level tracking
  int lo_run = 0;
  int p_t = -1;
  int p_s = 99;

  // reference model
  int q[$];
  string tq[$];
  int m_s = 99;
  bit m_quiet = 1'b0;
  logic [15:0] m_stat = '0;
  logic [15:0] m_stat_nx = '0;
  bit m_mgmt = 1'b0;
  bit m_mgmt_nx = 1'b0;
  bit m_quiet_nx = 1'b0;
  int cyc = 0;

  // entry code: [1:0] 0 release,1 low,2 high; bit2 vector update; bit3 stop high
  task automatic plan(input int lows, input string tg);
    int stop_len;
    stop_len = next_quiet ? 2 : 3;
    for (int i = 0; i < lows; i++) begin q.push_back(1); tq.push_back(tg); end
    q.push_back(2); tq.push_back(tg);
    for (int t = 1; t <= 49; t++) begin q.push_back(0); tq.push_back("R3"); end
    for (int i = 0; i < stop_len; i++) begin q.push_back(i == 0 ? 5 : 1); tq.push_back("R6"); end
    q.push_back(10); tq.push_back("R6");
    m_stat_nx = '0;
    for (int n = 2; n <= 16; n++) m_stat_nx[n-1] = pend[n];
    m_mgmt_nx = 1'b0;
    if (slot3_to_mgmt) begin m_mgmt_nx = pend[3]; m_stat_nx[2] = 1'b0; end
    m_quiet_nx = next_quiet;
  endtask

  always @(negedge clk) begin
    bit host_lvl, pl, idle, exp_oe, exp_out, exp_v;
    int e;
    string tag;
    if (!rst_n) begin
      periph_low = 1'b0;
      lo_run = 0; p_t = -1; p_s = 99;
      q.delete(); tq.delete();
      m_s = 99; m_quiet = 1'b0; m_stat = '0; m_mgmt = 1'b0;
    end else begin
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
      // peripheral: locate itself in the cycle from the wire history
      host_lvl = line_oe ? line_out : 1'b1;
      if (host_lvl && lo_run >= 4) p_t = 0;
      else if (host_lvl && (lo_run == 2 || lo_run == 3)) begin p_t = -1; p_s = 0; end
      else begin
        if (p_t >= 0) p_t++;
        if (p_s < 99) p_s++;
      end
      pl = 1'b0;
      if (p_t >= 2 && p_t <= 47 && (p_t % 3) == 2 && pend[(p_t + 1) / 3]) pl = 1'b1;
      if (want_req && p_t < 0 && p_s >= req_s && host_lvl) begin pl = 1'b1; want_req = 1'b0; end
      periph_low = pl;
      lo_run = (pl || !host_lvl) ? lo_run + 1 : 0;

      // reference comparison for this clock
      idle = (q.size() == 0);
      if (!idle) begin e = q.pop_front(); tag = tq.pop_front(); end
      else begin e = 0; tag = m_quiet ? "R10" : "R8"; end
      exp_oe  = (e[1:0] != 2'd0);
      exp_out = (e[1:0] == 2'd2);
      exp_v   = e[2];
      if (exp_v) begin m_stat = m_stat_nx; m_mgmt = m_mgmt_nx; m_quiet = m_quiet_nx; end
      if (e[3]) m_s = 0;
      else if (idle && m_s < 99) m_s++;
      chk(line_oe == exp_oe && (!exp_oe || line_out == exp_out), tag, "wire drive",
          {30'd0, line_oe, line_out}, {30'd0, exp_oe, exp_out});
      chk(status_valid == exp_v, "R7", "valid strobe", status_valid, exp_v);
      chk(irq_status == m_stat, "R3", "vector", irq_status, m_stat);
      chk(mgmt_irq == m_mgmt, "R5", "mgmt irq", mgmt_irq, m_mgmt);
      chk(mode_quiet == m_quiet, "R6", "mode", mode_quiet, m_quiet);

      // plan the next cycle (R11: only when enabled)
      if (q.size() == 0) begin
        if (enable && !m_quiet && m_s >= 1) plan(4, "R2");
        else if (enable && m_quiet && m_s >= 2 && pl) plan(3, "R9");
      end
    end
  end

  task automatic wait_valid(input string tg);
    int k;
    k = 0;
    do begin @(negedge clk); #1; k++; end while (!status_valid && k < 300);
    chk(status_valid, tg, "cycle completion", status_valid, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(line_oe == 1'b0, "R1", "reset drive", line_oe, 0);
    chk(irq_status == 16'h0, "R1", "reset vector", irq_status, 0);
    chk(status_valid == 1'b0 && mgmt_irq == 1'b0, "R1", "reset flags", {status_valid, mgmt_irq}, 0);
    chk(mode_quiet == 1'b0, "R1", "reset mode", mode_quiet, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(line_oe == 1'b0, "R11", "no start while disabled", line_oe, 0);

    // cycle A: slots 1,2,5,16
    pend[1] = 1'b1; pend[2] = 1'b1; pend[5] = 1'b1; pend[16] = 1'b1;
    enable = 1'b1;
    wait_valid("R2");
    chk(irq_status == 16'h8012, "R3", "vector slots 2,5,16", irq_status, 16'h8012);
    chk(irq_status[0] == 1'b0, "R4", "slot 1 dropped", irq_status[0], 0);

    // cycle B: slot 3 steered to management, slot 14
    @(posedge clk); #1;
    pend = '0; pend[3] = 1'b1; pend[7] = 1'b1; pend[14] = 1'b1;
    slot3_to_mgmt = 1'b1;
    wait_valid("R7");
    chk(mgmt_irq == 1'b1, "R5", "slot 3 on mgmt", mgmt_irq, 1);
    chk(irq_status == 16'h2040, "R5", "vector with steering", irq_status, 16'h2040);

    // cycle C: all slots, stop selects quiet
    @(posedge clk); #1;
    pend = '1; slot3_to_mgmt = 1'b0; next_quiet = 1'b1;
    wait_valid("R6");
    chk(irq_status == 16'hFFFE, "R4", "all slots", irq_status, 16'hFFFE);
    chk(mgmt_irq == 1'b0, "R5", "mgmt idle when bit 2 used", mgmt_irq, 0);
    chk(mode_quiet == 1'b1, "R6", "quiet selected", mode_quiet, 1);

    // too-early request then silence in quiet mode
    @(posedge clk); #1;
    pend = '0; want_req = 1'b1; req_s = 1;
    repeat (30) @(posedge clk);
    #1;
    chk(line_oe == 1'b0 && !status_valid, "R10", "early request ignored", line_oe, 0);

    // cycle D: timely request, stop returns to continuous
    pend[2] = 1'b1; pend[16] = 1'b1; next_quiet = 1'b0;
    want_req = 1'b1; req_s = 2;
    wait_valid("R9");
    chk(irq_status == 16'h8002, "R9", "request-started vector", irq_status, 16'h8002);
    chk(mode_quiet == 1'b0, "R6", "continuous selected", mode_quiet, 0);

    // disable in continuous mode
    @(posedge clk); #1;
    enable = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    chk(line_oe == 1'b0, "R11", "held off while disabled", line_oe, 0);
    pend = '0; pend[4] = 1'b1;
    enable = 1'b1;
    wait_valid("R8");
    chk(irq_status == 16'h0008, "R8", "vector after re-enable", irq_status, 16'h0008);

    repeat (10) @(posedge clk);
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule